// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the timing strobes for the output side of an interlaced video decoder. A single pixel clock drives it. It keeps a pixel counter and a line counter. From them it derives horizontal and vertical sync, horizontal and vertical blanking, a field flag that is high during the odd field, and a flag that tells a downstream 4:2:2 multiplexer whether the current chroma sample is Cb or Cr.

A three-bit mode input selects one of the supported sampling standards, each with its own line length and active width. Four window inputs set where active video begins and ends, both along the line and within each field. These inputs normally come from a register block elsewhere in the chip. The block samples the mode and the window values only at a frame boundary, so every frame is built from one consistent setting.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, `hSync`, `vSync` and `cbcrFlag` are 0, `hBlank`, `vBlank` and `oddField` are 1, and the position is set to line 1, pixel 0. Every output is registered. The first rising edge with `rst` low presents the decode of line 1, pixel 0, and each later edge presents the decode of the position one pixel further on.
- R2: Line length in pixel clocks is set by `modeSel`: code 0 gives 780 (525-line square pixel), code 1 gives 858 (525-line 601), code 2 gives 910 (525-line 4x subcarrier), code 3 gives 944 (625-line square pixel) and code 4 gives 864 (625-line 601). Codes 5 to 7 act as code 1. A frame is `LINES_525` lines for codes 0 to 2 and `LINES_625` lines for codes 3 and 4.
- R3: `hSync` is high for pixels 0 to `HSYNC_W`-1 of every line.
- R4: `hBlank` is low exactly for pixels p with `hActStart` <= p < stop. The stop is `hActStop` when that input is nonzero. When `hActStop` is 0, the stop is `hActStart` plus the mode's active width: 640 for code 0, 768 for codes 2 and 3, and 720 otherwise.
- R5: Lines are numbered within each field. With B = (frame lines - 1)/2, a frame line n <= B is field line n, and a later line n is field line n - B. `vBlank` is low exactly when `vActStart` <= field line < `vActStop`.
- R6: In 525-line modes, with H = 2*(line-1) + (1 when the pixel is in the second half of the line), `vSync` is high for 6 <= H < 12 (lines 4 to 6, after three equalizing lines) and for L+6 <= H < L+12, where L is the frame line count.
- R7: In 625-line modes, `vSync` is high for 0 <= H < 5 (two and a half lines from the start of line 1) and for L <= H < L+5 (starting half way through the middle line of the frame).
- R8: `oddField` is high for H < L and low for the rest of the frame. It rises only at line 1, pixel 0.
- R9: `cbcrFlag` is 0 (Cb) whenever `hBlank` is high. It is 0 on the first active pixel of a line and alternates on every following active pixel, with 1 meaning Cr.
- R10: `modeSel` and the four window inputs are sampled during reset and on the clock edge that wraps the last pixel of the last line. A change at any other time has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 3 | Sampling standard code |
| hActStart | input | 11 | First active pixel of a line |
| hActStop | input | 11 | Pixel after the last active one; 0 selects the mode width |
| vActStart | input | 10 | First active line of a field |
| vActStop | input | 10 | Line after the last active one in a field |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| oddField | output | 1 | High during the odd field |
| cbcrFlag | output | 1 | Chroma phase, 0 = Cb, 1 = Cr |

## Verification
On every cycle, the embedded properties check several things: the line wrap always follows the last pixel of the mode, the sampled settings hold still away from the frame origin, sync starts at pixel 0, the field flag rises only at the frame origin, and the chroma flag starts at Cb and then alternates inside each active run. They cannot show that the vertical sync windows fall on the right half-lines for each standard, that the blanking edges match the programmed window, or that a setting written mid-frame waits for the frame boundary. The bench covers these by running a reference model alongside the design through every mode code. Its window settings include an explicit stop, the mode default, a window that starts at pixel 0 and one that runs past the line end, and the settings change mid-frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int PIX_W  = 11;
  localparam int LINE_W = 10;
  localparam int HALF_W = LINE_W + 1;
  localparam int MODE_W = 3;

  // vertical sync windows in half-line units, relative to each field origin
  localparam int VS_OFS_525 = 6;
  localparam int VS_LEN_525 = 6;
  localparam int VS_OFS_625 = 0;
  localparam int VS_LEN_625 = 5;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    pix_t  hStart;
    pix_t  hStop;
    line_t vStart;
    line_t vStop;
  } winCfg_t;

  typedef struct packed {
    pix_t  totalPix;
    pix_t  activePix;
    line_t totalLines;
    logic  is625;
  } modeTim_t;

  // strobes handed from the counter control to the output datapath
  typedef struct packed {
    pix_t  pix;
    half_t halfLine;
    line_t fieldLine;
  } rasterStrb_t;

  function automatic modeTim_t lookupTiming(input mode_t mode,
                                            input line_t lines525,
                                            input line_t lines625);
    modeTim_t t;
    t.totalLines = lines525;
    t.is625      = 1'b0;
    case (mode)
      3'd0: begin t.totalPix = pix_t'(780); t.activePix = pix_t'(640); end
      3'd2: begin t.totalPix = pix_t'(910); t.activePix = pix_t'(768); end
      3'd3: begin
        t.totalPix = pix_t'(944); t.activePix = pix_t'(768);
        t.totalLines = lines625; t.is625 = 1'b1;
      end
      3'd4: begin
        t.totalPix = pix_t'(864); t.activePix = pix_t'(720);
        t.totalLines = lines625; t.is625 = 1'b1;
      end
      default: begin t.totalPix = pix_t'(858); t.activePix = pix_t'(720); end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rtg_raster_ctrl.sv
module rtg_raster_ctrl
  import rtg_pkg::*;
#(
  parameter int LINES_525 = 525,
  parameter int LINES_625 = 625
) (
  input  logic        clk,
  input  logic        rst,
  input  mode_t       modeIn,
  input  winCfg_t     winIn,
  output winCfg_t     winCur,
  output modeTim_t    timCur,
  output rasterStrb_t strb
);

  localparam line_t L525 = line_t'(LINES_525);
  localparam line_t L625 = line_t'(LINES_625);

  pix_t    pixCnt;
  line_t   lineCnt;
  mode_t   modeReg;
  winCfg_t winReg;
  logic    lastPix;
  logic    lastLine;
  line_t   fieldBase;

  assign timCur   = lookupTiming(modeReg, L525, L625);
  assign winCur   = winReg;
  assign lastPix  = (pixCnt == timCur.totalPix - pix_t'(1));
  assign lastLine = (lineCnt == timCur.totalLines);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixCnt  <= '0;
      lineCnt <= line_t'(1);
      modeReg <= modeIn;
      winReg  <= winIn;
    end else if (lastPix) begin
      pixCnt <= '0;
      if (lastLine) begin
        lineCnt <= line_t'(1);
        modeReg <= modeIn;
        winReg  <= winIn;
      end else begin
        lineCnt <= lineCnt + line_t'(1);
      end
    end else begin
      pixCnt <= pixCnt + pix_t'(1);
    end
  end

  assign fieldBase = (timCur.totalLines - line_t'(1)) >> 1;

  always_comb begin
    strb.pix       = pixCnt;
    strb.halfLine  = {lineCnt - line_t'(1), (pixCnt >= (timCur.totalPix >> 1))};
    strb.fieldLine = (lineCnt <= fieldBase) ? lineCnt : lineCnt - fieldBase;
  end

  AST_LINE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (pixCnt == '0 && !$past(rst)) |-> ($past(pixCnt) == $past(timCur.totalPix) - pix_t'(1))); // R2

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (lineCnt >= line_t'(1)) && (lineCnt <= timCur.totalLines)); // R2

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(pixCnt == '0 && lineCnt == line_t'(1)) |-> ($stable(modeReg) && $stable(winReg))); // R10

endmodule

// File: rtl/rtg_output_dp.sv
module rtg_output_dp
  import rtg_pkg::*;
#(
  parameter int HSYNC_W = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  rasterStrb_t strb,
  input  winCfg_t     win,
  input  modeTim_t    tim,
  output logic        hSync,
  output logic        vSync,
  output logic        hBlank,
  output logic        vBlank,
  output logic        oddField,
  output logic        cbcrFlag
);

  localparam pix_t HSW = pix_t'(HSYNC_W);

  pix_t  hStopEff;
  half_t fieldHalf;
  half_t vsBase;
  half_t vsLen;
  logic  hAct;
  logic  vAct;
  logic  vsOdd;
  logic  vsEven;

  always_comb begin
    hStopEff  = (win.hStop == '0) ? win.hStart + tim.activePix : win.hStop;
    hAct      = (strb.pix >= win.hStart) && (strb.pix < hStopEff);
    vAct      = (strb.fieldLine >= win.vStart) && (strb.fieldLine < win.vStop);
    fieldHalf = half_t'(tim.totalLines);
    vsBase    = tim.is625 ? half_t'(VS_OFS_625) : half_t'(VS_OFS_525);
    vsLen     = tim.is625 ? half_t'(VS_LEN_625) : half_t'(VS_LEN_525);
    vsOdd     = (strb.halfLine >= vsBase) && (strb.halfLine < vsBase + vsLen);
    vsEven    = (strb.halfLine >= fieldHalf + vsBase) &&
                (strb.halfLine < fieldHalf + vsBase + vsLen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hSync    <= 1'b0;
      vSync    <= 1'b0;
      hBlank   <= 1'b1;
      vBlank   <= 1'b1;
      oddField <= 1'b1;
      cbcrFlag <= 1'b0;
    end else begin
      hSync    <= (strb.pix < HSW);
      vSync    <= vsOdd || vsEven;
      hBlank   <= !hAct;
      vBlank   <= !vAct;
      oddField <= (strb.halfLine < fieldHalf);
      cbcrFlag <= hAct && (strb.pix[0] ^ win.hStart[0]);
    end
  end

  AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    strb.pix < tim.totalPix); // R2

  AST_HSYNC_LINE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(hSync) |-> ($past(strb.pix) == '0)); // R3

  AST_ODD_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(oddField) |-> ($past(strb.pix) == '0 && $past(strb.halfLine) == '0)); // R8

  AST_CBCR_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    hBlank |-> !cbcrFlag); // R9

  AST_CBCR_FIRST_CB: assert property (@(posedge clk) disable iff (rst)
    $fell(hBlank) |-> !cbcrFlag); // R9

  AST_CBCR_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (!hBlank && !$past(hBlank)) |-> (cbcrFlag != $past(cbcrFlag))); // R9

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int LINES_525 = 525,
  parameter int LINES_625 = 625,
  parameter int HSYNC_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [PIX_W-1:0]  hActStart,
  input  logic [PIX_W-1:0]  hActStop,
  input  logic [LINE_W-1:0] vActStart,
  input  logic [LINE_W-1:0] vActStop,
  output logic              hSync,
  output logic              vSync,
  output logic              hBlank,
  output logic              vBlank,
  output logic              oddField,
  output logic              cbcrFlag
);

  winCfg_t     winIn;
  winCfg_t     winCur;
  modeTim_t    timCur;
  rasterStrb_t strb;

  assign winIn = '{hStart: hActStart, hStop: hActStop,
                   vStart: vActStart, vStop: vActStop};

  rtg_raster_ctrl #(
    .LINES_525(LINES_525),
    .LINES_625(LINES_625)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .modeIn(modeSel),
    .winIn (winIn),
    .winCur(winCur),
    .timCur(timCur),
    .strb  (strb)
  );

  rtg_output_dp #(
    .HSYNC_W(HSYNC_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .win     (winCur),
    .tim     (timCur),
    .hSync   (hSync),
    .vSync   (vSync),
    .hBlank  (hBlank),
    .vBlank  (vBlank),
    .oddField(oddField),
    .cbcrFlag(cbcrFlag)
  );

endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;

  localparam int NL525 = 15;
  localparam int NL625 = 17;
  localparam int HSW   = 64;
  localparam int STEP_CYCLES = 17000;
  localparam int WATCHDOG    = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  modeSel = '0;
  logic [10:0] hActStart = '0;
  logic [10:0] hActStop = '0;
  logic [9:0]  vActStart = '0;
  logic [9:0]  vActStop = '0;
  logic hSync, vSync, hBlank, vBlank, oddField, cbcrFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(
    .LINES_525(NL525),
    .LINES_625(NL625),
    .HSYNC_W  (HSW)
  ) u_raster_timing_gen (
    .clk(clk), .rst(rst), .modeSel(modeSel),
    .hActStart(hActStart), .hActStop(hActStop),
    .vActStart(vActStart), .vActStop(vActStop),
    .hSync(hSync), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
    .oddField(oddField), .cbcrFlag(cbcrFlag)
  );

  // expected item: {is625, hSync, vSync, hBlank, vBlank, oddField, cbcrFlag}
  logic [6:0] expQ[$];

  int mPix, mLine, mMode, mHs, mHe, mVs, mVe;

  function automatic void modeInfo(input int md, output int tot, output int act,
                                   output int lines, output bit p625);
    p625 = 1'b0; lines = NL525;
    case (md)
      0: begin tot = 780; act = 640; end
      2: begin tot = 910; act = 768; end
      3: begin tot = 944; act = 768; lines = NL625; p625 = 1'b1; end
      4: begin tot = 864; act = 720; lines = NL625; p625 = 1'b1; end
      default: begin tot = 858; act = 720; end
    endcase
  endfunction

  function automatic logic [6:0] predict(input int p, input int ln, input int md,
                                         input int hs, input int he,
                                         input int vs, input int ve);
    int tot, act, lines, half, stopE, base, fl, vo, vl;
    bit p625, eh, ev, eha, eva, eo, ec;
    modeInfo(md, tot, act, lines, p625);
    half  = 2 * (ln - 1) + ((p >= tot / 2) ? 1 : 0);
    stopE = (he == 0) ? hs + act : he;
    base  = (lines - 1) / 2;
    fl    = (ln <= base) ? ln : ln - base;
    vo    = p625 ? 0 : 6;
    vl    = p625 ? 5 : 6;
    eh  = (p < HSW);
    ev  = ((half >= vo) && (half < vo + vl)) ||
          ((half >= lines + vo) && (half < lines + vo + vl));
    eha = (p >= hs) && (p < stopE);
    eva = (fl >= vs) && (fl < ve);
    eo  = (half < lines);
    ec  = eha && (((p - hs) % 2) == 1);
    return {p625, eh, ev, !eha, !eva, eo, ec};
  endfunction

  // reference model: pushes the expected outputs for each active clock edge
  always @(posedge clk) begin
    int tot, act, lines;
    bit p625;
    if (rst) begin
      mPix = 0; mLine = 1;
      mMode = int'(modeSel); mHs = int'(hActStart); mHe = int'(hActStop);
      mVs = int'(vActStart); mVe = int'(vActStop);
      expQ.delete();
    end else begin
      expQ.push_back(predict(mPix, mLine, mMode, mHs, mHe, mVs, mVe));
      modeInfo(mMode, tot, act, lines, p625);
      if (mPix == tot - 1) begin
        mPix = 0;
        if (mLine == lines) begin
          mLine = 1;
          // R10: settings are taken only at the frame wrap
          mMode = int'(modeSel); mHs = int'(hActStart); mHe = int'(hActStop);
          mVs = int'(vActStart); mVe = int'(vActStop);
        end else begin
          mLine = mLine + 1;
        end
      end else begin
        mPix = mPix + 1;
      end
    end
  end

  task automatic checkBit(input string req, input string name, input int cyc,
                          input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d %s actual %b expected %b", req, cyc, name, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle and compares
  int cyc = 0;
  always @(negedge clk) begin
    logic [6:0] e;
    if (!rst && expQ.size() > 0 && !done) begin
      cyc++;
      e = expQ.pop_front();
      checkBit("R2 R3", "hSync", cyc, hSync, e[5]);
      checkBit(e[6] ? "R7" : "R6", "vSync", cyc, vSync, e[4]);
      checkBit("R4 R10", "hBlank", cyc, hBlank, e[3]);
      checkBit("R5", "vBlank", cyc, vBlank, e[2]);
      checkBit("R8", "oddField", cyc, oddField, e[1]);
      checkBit("R9", "cbcrFlag", cyc, cbcrFlag, e[0]);
    end
  end

  task automatic applyStep(input int md, input int hs, input int he,
                           input int vs, input int ve);
    @(negedge clk);
    modeSel = 3'(md); hActStart = 11'(hs); hActStop = 11'(he);
    vActStart = 10'(vs); vActStop = 10'(ve);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    applyStep(0, 100, 0, 3, 6);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R1: reset values
      checkBit("R1", "hSync", 0, hSync, 1'b0);
      checkBit("R1", "vSync", 0, vSync, 1'b0);
      checkBit("R1", "hBlank", 0, hBlank, 1'b1);
      checkBit("R1", "vBlank", 0, vBlank, 1'b1);
      checkBit("R1", "oddField", 0, oddField, 1'b1);
      checkBit("R1", "cbcrFlag", 0, cbcrFlag, 1'b0);
    end
    rst = 1'b0;
    @(negedge clk);
    // R1: first edge after reset shows line 1, pixel 0
    checkBit("R1", "hSync first", 0, hSync, 1'b1);
    checkBit("R1", "hBlank first", 0, hBlank, 1'b1);
    checkBit("R1", "oddField first", 0, oddField, 1'b1);
    repeat (2000) @(negedge clk);
    // settings below change mid-frame and must wait for the wrap (R10)
    applyStep(1, 122, 0, 2, 7);   repeat (STEP_CYCLES) @(negedge clk);
    applyStep(2, 0, 0, 1, 8);     repeat (STEP_CYCLES) @(negedge clk);
    applyStep(3, 150, 0, 2, 9);   repeat (STEP_CYCLES) @(negedge clk);
    applyStep(4, 130, 0, 3, 8);   repeat (STEP_CYCLES) @(negedge clk);
    applyStep(4, 201, 500, 0, 2); repeat (STEP_CYCLES) @(negedge clk);
    applyStep(7, 800, 2000, 4, 9); repeat (STEP_CYCLES) @(negedge clk);
    applyStep(3, 0, 0, 1, 20);    repeat (STEP_CYCLES) @(negedge clk);
    applyStep(0, 33, 0, 2, 5);    repeat (STEP_CYCLES) @(negedge clk);
    finishRun();
  end

endmodule